// File: doc/BRIEF.md
# Piecewise-Linear Mantissa Reciprocal

This combinational unit returns an approximation of y = 1/x for a normalized floating-point mantissa x in [1,2). The caller supplies only the fraction bits of x; the leading one is implied. Inside, two straight-line segments stand in for the curve. Each segment has the form constant minus a slope times x, and every slope is the sum of two powers of two. The arithmetic therefore needs only wired right shifts, two subtractions per segment and a 2:1 multiplexer. No multiplier is involved.

The most significant fraction bit decides which segment is used. Segment L covers x < 1.5 and has y = 1.59375 - 0.625·x. Segment H covers x ≥ 1.5 and has y = 1.125 - 0.3125·x. The arithmetic runs at four more fraction bits than the input, so every shifted term is exact. The result is cut to eight fraction bits at the very end. A typical use is the shared reciprocal of a normalized sum mantissa in a normalize-by-sum datapath: the exponent is handled elsewhere, and the output mantissa is renormalized downstream.

Top module: `recip_pwl_top`

## Requirements
- R1: The input `frac_i` = f encodes x = 1 + f/256. The output `recip_o` = q is unsigned, with 1 integer bit (bit 8) and 8 fraction bits, so y = q/256. For example, f=64 (x=1.25) gives q=208.
- R2: When bit 7 of f is 0, q = floor((3968 - 10·f)/16). This is 1.59375 - 0.625·x with exact intermediates, truncated to 8 fraction bits.
- R3: When bit 7 of f is 1, q = floor((3328 - 5·f)/16). This is 1.125 - 0.3125·x with exact intermediates, truncated to 8 fraction bits.
- R4: Bit 7 of f (weight 2^-1) alone selects the segment. f=127 uses the x<1.5 segment and gives q=168. f=128 uses the x≥1.5 segment and gives q=168. f=255 gives q=128, where the other segment would give 88.
- R5: For every input, |1/x - y| ≤ 2^-5 + 2^-8. In integer terms, |65536 - q·(256+f)| ≤ 9·(256+f).
- R6: At x = 1.0 (f=0), q = 248, which is an error of exactly 2^-5.
- R7: Over f = 0..255, q never increases from one code to the next, including across the segment switch.
- R8: The integer bit of q is always 0 and q ≥ 128, so y lies in [0.5, 1).
- R9: The unit holds no state. The output depends only on the present input, whatever value came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| frac_i | input | 8 | Fraction bits of the mantissa x (leading one implied) |
| recip_o | output | 9 | Approximate 1/x, 1 integer bit and 8 fraction bits |

## Verification
The embedded assertions are evaluated whenever the input changes. They check that neither segment's subtraction borrows, that the integer bit stays clear, that the output never falls below one half, and that the selected output is never below either segment's value (a property the two lines have on their own halves). Only the bench's sweeps can show the rest. The exact code for each of the 256 inputs, the error bound against the true reciprocal, monotonic descent across the switch at x = 1.5, and the independence from the preceding input all come from the bench, because each depends on values outside a single evaluation.

// File: rtl/recip_pwl_pkg.sv
package recip_pwl_pkg;

  // default widths of the mantissa fraction and of the guard extension
  localparam int FRAC_W_DEF  = 8;
  localparam int GUARD_W_DEF = 4;

  // number of linear segments and their selection: index 0 below 1.5, 1 above
  localparam int NUM_SEG = 2;

  // segment offsets written as numerator / 2^log2den
  // 1.10011b = 51/32, 1.001b = 9/8
  localparam int SEG_NUM  [NUM_SEG] = '{51, 9};
  localparam int SEG_LOG2 [NUM_SEG] = '{5, 3};

  // slope = 2^-SEG_SH_A + 2^-SEG_SH_B
  localparam int SEG_SH_A [NUM_SEG] = '{1, 2};
  localparam int SEG_SH_B [NUM_SEG] = '{3, 4};

  // offset scaled to a fixed-point value with work_f fraction bits
  function automatic int seg_offset(input int num, input int log2den, input int work_f);
    return num << (work_f - log2den);
  endfunction

  // slope term: x scaled by 2^-sh_a + 2^-sh_b, with x already in work units
  function automatic int slope_term(input int x_work, input int sh_a, input int sh_b);
    return (x_work >> sh_a) + (x_work >> sh_b);
  endfunction

endpackage

// File: rtl/recip_pwl_seg.sv
module recip_pwl_seg
  import recip_pwl_pkg::*;
#(
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int GUARD_W = GUARD_W_DEF,
  parameter int C_NUM   = 51,
  parameter int C_LOG2  = 5,
  parameter int SH_A    = 1,
  parameter int SH_B    = 3
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W:0]   y_o
);

  localparam int WORK_F = FRAC_W + GUARD_W;
  localparam int WORK_W = WORK_F + 2;   // integer bit plus borrow bit
  localparam logic [WORK_W-1:0] OFFSET = WORK_W'(seg_offset(C_NUM, C_LOG2, WORK_F));

  logic [WORK_W-1:0] x_work;
  logic [WORK_W-1:0] term_a;
  logic [WORK_W-1:0] term_b;
  logic [WORK_W-1:0] diff;
  logic [WORK_W-1:0] scaled;

  always_comb begin
    x_work = {2'b01, frac_i, {GUARD_W{1'b0}}};
    term_a = x_work >> SH_A;
    term_b = x_work >> SH_B;
    diff   = OFFSET - term_a - term_b;
    scaled = diff >> GUARD_W;
    y_o    = scaled[FRAC_W:0];
  end

  // named event: bits above the output field, set only on a borrow
  logic [WORK_W-FRAC_W-2:0] seg_overhang;
  assign seg_overhang = scaled[WORK_W-1:FRAC_W+1];

  always_comb begin
    AST_SEG_NO_BORROW: assert (seg_overhang == '0); // R2
  end

endmodule

// File: rtl/recip_pwl_sel.sv
module recip_pwl_sel #(
  parameter int W = 9
) (
  input  logic         sel_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    y_o = sel_i ? hi_i : lo_i;
  end

endmodule

// File: rtl/recip_pwl_top.sv
module recip_pwl_top
  import recip_pwl_pkg::*;
#(
  parameter int FRAC_W  = FRAC_W_DEF,
  parameter int GUARD_W = GUARD_W_DEF
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W:0]   recip_o
);

  localparam int OUT_W = FRAC_W + 1;
  localparam logic [OUT_W-1:0] HALF = OUT_W'(1) << (FRAC_W - 1);

  logic [OUT_W-1:0] seg_y [NUM_SEG];
  logic             seg_pick;

  assign seg_pick = frac_i[FRAC_W-1];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    recip_pwl_seg #(
      .FRAC_W (FRAC_W),
      .GUARD_W(GUARD_W),
      .C_NUM  (SEG_NUM[s]),
      .C_LOG2 (SEG_LOG2[s]),
      .SH_A   (SEG_SH_A[s]),
      .SH_B   (SEG_SH_B[s])
    ) u_seg (
      .frac_i(frac_i),
      .y_o   (seg_y[s])
    );
  end

  recip_pwl_sel #(.W(OUT_W)) u_sel (
    .sel_i(seg_pick),
    .lo_i (seg_y[0]),
    .hi_i (seg_y[1]),
    .y_o  (recip_o)
  );

  always_comb begin
    AST_INT_BIT_CLEAR: assert (recip_o[FRAC_W] == 1'b0); // R8
    AST_OUT_FLOOR: assert (recip_o >= HALF); // R8
    AST_SEL_UPPER_ENVELOPE: assert (recip_o >= seg_y[0] && recip_o >= seg_y[1]); // R4
  end

endmodule

// File: tb/recip_pwl_top_test.sv
module recip_pwl_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] frac;
  logic [8:0] recip;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recip_pwl_top uut (
    .frac_i (frac),
    .recip_o(recip)
  );

  // behavioural model from the requirement formulas
  function automatic int model_q(input int f);
    if (f < 128) return (3968 - 10 * f) / 16;
    return (3328 - 5 * f) / 16;
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int f);
    @(posedge clk);
    #1 frac = 8'(f);
    @(negedge clk);
  endtask

  // compare on every clock after reset
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(recip) == model_q(int'(frac)), (frac[7] ? "R3" : "R2"),
            int'(recip), model_q(int'(frac)));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev_q;
    rst_n = 1'b0;
    frac  = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(recip == 9'd248, "R6", int'(recip), 248);           // R6 x=1.0
    rst_n = 1'b1;

    // ascending exhaustive sweep
    prev_q = 512;
    for (int f = 0; f < 256; f++) begin
      int q;
      apply(f);
      q = int'(recip);
      check(abs_i(65536 - q * (256 + f)) <= 9 * (256 + f), "R5", q, model_q(f));
      check(recip[8] == 1'b0 && q >= 128, "R8", q, model_q(f));
      check(q <= prev_q, "R7", q, prev_q);
      prev_q = q;
    end

    // specific points
    apply(64);
    check(recip == 9'd208, "R1", int'(recip), 208);
    apply(127);
    check(recip == 9'd168, "R4", int'(recip), 168);
    apply(128);
    check(recip == 9'd168, "R4", int'(recip), 168);
    apply(255);
    check(recip == 9'd128, "R4", int'(recip), 128);
    apply(0);
    check(recip == 9'd248, "R6", int'(recip), 248);

    // scrambled order: same codes reached from different predecessors
    for (int i = 0; i < 256; i++) begin
      int f;
      f = (i * 37 + 11) % 256;
      apply(f);
      check(int'(recip) == model_q(f), "R9", int'(recip), model_q(f));
    end

    // descending sweep
    for (int f = 255; f >= 0; f--) begin
      apply(f);
      check(int'(recip) == model_q(f), "R9", int'(recip), model_q(f));
    end

    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule